// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits beside the fetch stage of a four-stage pipeline (fetch, decode, execute, write-back). When the pipeline resolves a taken branch, it presents the branch's source address, its target address, and the target instruction as it arrives from program memory. The block looks the source address up in a small, fully associative store. On a hit it hands the stored target instruction and its length to decode in the same cycle, so the branch leaves no bubble. On a miss it records the instruction for the next time that branch is taken and raises a stall pulse for the penalty cycles.

A miss costs one cycle. A 4-byte target instruction that is not on a double-word boundary costs one more cycle on a miss. Each entry holds the full source address as its tag, up to 32 bits of instruction and a length flag. Entries are replaced in round-robin order. An explicit flush or any write to program memory clears every entry.

Top module: `brtgt_cache`

## Requirements
- R1: After reset, no entry is valid, `hit` is 0, `instr` is 0 and `stall` is 0.
- R2: A branch that is accepted and misses gives `hit`=0 in its own cycle. If the target instruction is short (`mem_long`=0), or long with target address bit 1 clear, `stall` is high for exactly the one cycle after it.
- R3: A branch that is accepted and misses, with `mem_long`=1 and target address bit 1 set, raises `stall` for exactly the two cycles after it.
- R4: A miss stores the source address, the instruction and the length. From the next cycle, an accepted branch with the same source address gives `hit`=1 in the same cycle, with that instruction and length.
- R5: On a hit, `instr_long`=1 means a 4-byte instruction and `instr` carries all 32 stored bits. `instr_long`=0 means a 2-byte instruction, and `instr[31:16]` is 0 while `instr[15:0]` holds the stored low half.
- R6: A hit never starts a stall, whatever its length or alignment.
- R7: Entries fill in round-robin order from index 0. With ENTRIES entries full, the next miss evicts the oldest allocation, and that branch misses when it is taken again.
- R8: `flush` invalidates every entry and returns the allocation order to index 0. This takes effect from the next cycle. A miss in the same cycle as `flush` is charged its stall but is not stored.
- R9: `prog_wr` has the same invalidating effect as `flush`.
- R10: A branch presented while `stall` is high is ignored. It gives `hit`=0 and `instr`=0, stores nothing and does not lengthen the stall.
- R11: With `br_valid`=0, `hit`, `instr` and `instr_long` are all 0.
- R12: The tag compare uses every bit of the source address. An address that differs from a stored tag in any single bit misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A taken branch is resolved this cycle |
| br_src | input | AW (24) | Byte address of the branch instruction (tag) |
| br_tgt | input | AW (24) | Byte address of the branch target |
| mem_instr | input | 32 | Target instruction as fetched from program memory |
| mem_long | input | 1 | Fetched target instruction is 4 bytes long |
| flush | input | 1 | Invalidate all entries |
| prog_wr | input | 1 | A write to program memory occurred |
| hit | output | 1 | Stored target instruction is supplied this cycle |
| instr | output | 32 | Supplied target instruction |
| instr_long | output | 1 | Supplied instruction is 4 bytes long |
| stall | output | 1 | Penalty cycle in progress |

## Verification
Random branch streams are drawn from a small pool of source addresses, so the run mixes first-time misses, repeat hits and evictions once the pool exceeds the entry count. These streams test associative lookup and round-robin order together. Random target alignment and length split the one-cycle miss charge from the two-cycle one. They also show that hits stay free whatever the alignment. Branches that land inside stall windows check that nothing is stored or lengthened while stalled. Directed cases cover the rest: one-bit tag differences, a flush or program write in the same cycle as a miss, and short instructions whose stored upper half is nonzero.

// File: rtl/btc_pkg.sv
package btc_pkg;
  // stall lengths charged for a miss
  localparam int unsigned PEN_BASE  = 1;
  localparam int unsigned PEN_EXTRA = 1;
  localparam int unsigned PEN_W     = 2;

  typedef struct packed {
    logic        lng;
    logic [31:0] ins;
  } payload_t;
endpackage

// File: rtl/btc_store.sv
module btc_store
  import btc_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned AW      = 24,
  localparam int unsigned IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [AW-1:0]   wr_tag,
  input  payload_t        wr_pay,
  input  logic [AW-1:0]   rd_tag,
  output logic            rd_hit,
  output payload_t        rd_pay
);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] match;
  logic [AW-1:0]      tag_q [ENTRIES];
  payload_t           pay_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic           sel;
    logic [AW-1:0]  tag_d;
    payload_t       pay_d;

    always_comb begin
      sel      = wr_en && (wr_idx == IDXW'(g));
      vld_d[g] = vld_q[g];
      tag_d    = tag_q[g];
      pay_d    = pay_q[g];
      if (clr) begin
        vld_d[g] = 1'b0;
      end else if (sel) begin
        vld_d[g] = 1'b1;
        tag_d    = wr_tag;
        pay_d    = wr_pay;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else        vld_q[g] <= vld_d[g];
    end

    // storage without reset; qualified by the valid bit
    always_ff @(posedge clk) begin
      if (sel && !clr) begin
        tag_q[g] <= tag_d;
        pay_q[g] <= pay_d;
      end
    end

    assign match[g] = vld_q[g] && (tag_q[g] == rd_tag);
  end

  always_comb begin
    rd_pay = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) rd_pay = rd_pay | pay_q[i];
    end
  end

  assign rd_hit = |match;

  // R4: an entry is only allocated on a miss, so tags never repeat
  a_r4_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R8: a clear empties every entry by the next cycle
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

endmodule

// File: rtl/btc_rr.sv
module btc_rr #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [IDXW-1:0] ptr
);

  logic [IDXW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (adv) begin
      if (ptr_q == IDXW'(ENTRIES - 1)) ptr_d = '0;
      else                             ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R7: pointer stays inside the entry range
  a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= IDXW'(ENTRIES - 1));

  // R7: an idle cycle leaves the order unchanged
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr_q));

endmodule

// File: rtl/btc_pen.sv
module btc_pen
  import btc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic extra,
  output logic stall
);

  logic [PEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else if (start)   cnt_d = extra ? PEN_W'(PEN_BASE + PEN_EXTRA) : PEN_W'(PEN_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stall = (cnt_q != '0);

  // R2: a started penalty is visible on the next cycle
  a_r2_stall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stall) |=> stall);

  // R3: a two-cycle penalty runs down to one
  a_r3_two_then_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == PEN_W'(2)) |=> (cnt_q == PEN_W'(1)));

  // R10: a start during a stall does not extend it
  a_r10_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == PEN_W'(1)) |=> !stall);

endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
  import btc_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned AW      = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_tgt,
  input  logic [31:0]   mem_instr,
  input  logic          mem_long,
  input  logic          flush,
  input  logic          prog_wr,
  output logic          hit,
  output logic [31:0]   instr,
  output logic          instr_long,
  output logic          stall
);

  localparam int unsigned IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic            accept, miss, inv, alloc, misalign;
  logic            rd_hit;
  payload_t        rd_pay, wr_pay;
  logic [IDXW-1:0] ptr;

  always_comb begin
    inv      = flush | prog_wr;
    accept   = br_valid & ~stall;
    miss     = accept & ~rd_hit;
    alloc    = miss & ~inv;
    misalign = mem_long & br_tgt[1];
    wr_pay   = '{lng: mem_long, ins: mem_instr};
  end

  btc_store #(.ENTRIES(ENTRIES), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (inv),
    .wr_en  (alloc),
    .wr_idx (ptr),
    .wr_tag (br_src),
    .wr_pay (wr_pay),
    .rd_tag (br_src),
    .rd_hit (rd_hit),
    .rd_pay (rd_pay)
  );

  btc_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (inv),
    .adv   (alloc),
    .ptr   (ptr)
  );

  btc_pen u_pen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (miss),
    .extra (misalign),
    .stall (stall)
  );

  always_comb begin
    hit        = accept & rd_hit;
    instr_long = hit & rd_pay.lng;
    instr      = '0;
    if (hit) instr = rd_pay.lng ? rd_pay.ins : {16'h0000, rd_pay.ins[15:0]};
  end

  // R6: a hit never launches a penalty
  a_r6_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !stall) |=> !stall);

  // R11: nothing is supplied without a branch
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> (!hit && instr == 32'h0 && !instr_long));

  // R5: a short instruction never carries an upper half
  a_r5_short_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !instr_long) |-> (instr[31:16] == 16'h0000));

endmodule

// File: tb/sim_brtgt_cache.sv
module sim_brtgt_cache;
  localparam int unsigned ENTRIES = 4;
  localparam int unsigned AW      = 24;
  localparam time         CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_valid, mem_long, flush, prog_wr;
  logic [AW-1:0] br_src, br_tgt;
  logic [31:0]   mem_instr;
  logic          hit, instr_long, stall;
  logic [31:0]   instr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [AW-1:0] m_tag [ENTRIES];
  logic [31:0]   m_ins [ENTRIES];
  logic          m_lng [ENTRIES];
  logic          m_vld [ENTRIES];
  int            m_ptr;
  int            m_cnt;

  logic [AW-1:0] pool [6];

  always #(CLK_PER/2) clk = ~clk;

  brtgt_cache #(.ENTRIES(ENTRIES), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
    .br_tgt(br_tgt), .mem_instr(mem_instr), .mem_long(mem_long),
    .flush(flush), .prog_wr(prog_wr), .hit(hit), .instr(instr),
    .instr_long(instr_long), .stall(stall)
  );

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < ENTRIES; i++)
      if (m_vld[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
    m_cnt = 0;
  endtask

  // drive one cycle at the falling edge, check, then update the model
  task automatic cyc(input logic v, input logic [AW-1:0] s, input logic [AW-1:0] t,
                     input logic [31:0] d, input logic l, input logic f, input logic w,
                     input string req);
    int idx;
    logic acc, e_hit;
    logic [31:0] e_ins;
    @(negedge clk);
    br_valid = v; br_src = s; br_tgt = t; mem_instr = d; mem_long = l;
    flush = f; prog_wr = w;
    #1;
    acc   = v && (m_cnt == 0);
    idx   = m_find(s);
    e_hit = acc && (idx >= 0);
    e_ins = 32'h0;
    if (e_hit) e_ins = m_lng[idx] ? m_ins[idx] : {16'h0, m_ins[idx][15:0]};
    chk({req, " hit"},   64'(hit),        64'(e_hit));
    chk({req, " instr"}, 64'(instr),      64'(e_ins));
    chk({req, " len"},   64'(instr_long), 64'(e_hit && m_lng[idx]));
    chk({req, " stall"}, 64'(stall),      64'(m_cnt != 0));
    @(posedge clk);
    #1;
    if (m_cnt != 0) m_cnt--;
    else if (acc && idx < 0) m_cnt = (l && t[1]) ? 2 : 1;
    if (f || w) begin
      m_reset_keep_cnt();
    end else if (acc && idx < 0) begin
      m_tag[m_ptr] = s; m_ins[m_ptr] = d; m_lng[m_ptr] = l; m_vld[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % ENTRIES;
    end
  endtask

  task automatic m_reset_keep_cnt();
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic idle(input string req);
    cyc(1'b0, '0, '0, 32'h0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic br(input logic [AW-1:0] s, input logic [AW-1:0] t,
                    input logic [31:0] d, input logic l, input string req);
    cyc(1'b1, s, t, d, l, 1'b0, 1'b0, req);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 3; k++) idle(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1998));
    pool[0] = 24'h000100; pool[1] = 24'h000104; pool[2] = 24'h00200a;
    pool[3] = 24'h003000; pool[4] = 24'h0040fe; pool[5] = 24'h005552;
    rst_n = 1'b0; br_valid = 0; br_src = '0; br_tgt = '0; mem_instr = '0;
    mem_long = 0; flush = 0; prog_wr = 0;
    m_reset();
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 hit", 64'(hit), 64'd0);
    chk("R1 instr", 64'(instr), 64'd0);
    chk("R1 stall", 64'(stall), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    idle("R1 R11 idle after reset");

    // R2: short miss -> one stall cycle; R4 then hit
    br(24'h000200, 24'h000300, 32'hdead_1234, 1'b0, "R2 short miss");
    idle("R2 stall cycle");
    idle("R2 stall end");
    br(24'h000200, 24'h000300, 32'h0, 1'b0, "R4 R5 short hit");
    // R3: misaligned long miss -> two stall cycles
    br(24'h000210, 24'h000302, 32'hcafe_babe, 1'b1, "R3 misaligned miss");
    // R10: branch during stall is ignored
    br(24'h000220, 24'h000310, 32'h1111_2222, 1'b1, "R10 during stall");
    idle("R3 second stall");
    idle("R3 stall end");
    br(24'h000220, 24'h000310, 32'h3333_4444, 1'b1, "R10 not stored");
    drain("R2 aligned long drain");
    // R6: misaligned long hit costs nothing
    br(24'h000210, 24'h000302, 32'h0, 1'b1, "R6 R5 long hit");
    idle("R6 no stall after hit");
    // R12: one-bit tag differences
    br(24'h000211, 24'h000302, 32'h5555_0001, 1'b0, "R12 low bit diff");
    drain("R12 drain");
    br(24'h800210, 24'h000302, 32'h5555_0002, 1'b0, "R12 high bit diff");
    drain("R12 drain");
    // R8: flush in same cycle as a miss
    cyc(1'b1, 24'h000600, 24'h0, 32'h7777_0000, 1'b0, 1'b1, 1'b0, "R8 flush with miss");
    drain("R8 drain");
    br(24'h000200, 24'h000300, 32'h0, 1'b0, "R8 flushed entry misses");
    drain("R8 drain");
    br(24'h000600, 24'h0, 32'h0, 1'b0, "R8 miss not stored");
    drain("R8 drain");
    // R9: program write invalidates
    cyc(1'b0, '0, '0, 32'h0, 1'b0, 1'b0, 1'b1, "R9 prog write");
    br(24'h000200, 24'h000300, 32'h0, 1'b0, "R9 invalidated");
    drain("R9 drain");
    // R7: fill all entries then evict the oldest
    cyc(1'b0, '0, '0, 32'h0, 1'b0, 1'b1, 1'b0, "R7 clean");
    for (int i = 0; i < ENTRIES + 1; i++) begin
      br(24'h010000 + 24'(i*4), 24'h0, 32'h0a00_0000 + 32'(i), 1'b1, "R7 fill");
      drain("R7 drain");
    end
    br(24'h010000, 24'h0, 32'h0, 1'b1, "R7 oldest evicted");
    drain("R7 drain");

    // random traffic over a small address pool
    for (int n = 0; n < 3000; n++) begin
      logic v, l, f, w;
      logic [AW-1:0] t;
      v = ($urandom % 4) != 0;
      l = $urandom % 2;
      f = ($urandom % 97) == 0;
      w = ($urandom % 89) == 0;
      t = AW'($urandom) & ~AW'(1);
      cyc(v, pool[$urandom % 6], t, $urandom, l, f, w, "R2 R3 R4 R7 R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule